// File: doc/BRIEF.md
# RC Oscillator Trim Selector and Clock Frequency Meter

This block serves an on-chip RC oscillator in two ways. It holds one trim code and one source select bit for each of the oscillator's three frequency ranges (low, middle, high). A range uses its factory code while its select bit is clear and the user-written code while it is set. The `range_i` input names the range the oscillator is running in, and the matching code is driven on `trim_o` by combinational logic. A write therefore reaches the oscillator on the next cycle, and the oscillator keeps running while its trim changes.

The block also measures the main clock against the slow clock. The slow clock arrives as a data input, passes through a two-flop synchroniser, and its rising edges mark the window. After a restart request the block waits for the next synchronised slow rising edge. It then counts main-clock cycles until 16 further slow rising edges have been seen, and raises a ready flag. The count is held until the next restart. Software reads the count, compares it with its own target and writes a corrected user trim. One measurement is started automatically when reset is released.

Top module: `rc_trim_fmeter`

## Requirements
- R1: `range_i` selects the trim on `trim_o`: 0 is low, 1 is middle, 2 is high, and 3 also selects high. Each range holds its own user code and its own select bit, so a write to one range leaves the others unchanged.
- R2: A range whose select bit is 0 drives its factory input on `trim_o`. A range whose select bit is 1 drives its stored user code.
- R3: After power-up reset, and after any later assertion of `rst_n`, every select bit is 0 and every user code is 0. `trim_o` then shows the factory code of the selected range.
- R4: A write (`usr_we` high, with `usr_range` 0 to 2) stores `usr_trim` and `usr_sel` for that range. If that range is active, the new value is on `trim_o` in the cycle after the write edge. A write with `usr_range` equal to 3 has no effect.
- R5: In the cycle after `meas_start` is sampled high, `meas_ready` is 0 and `meas_count` is 0. This holds whatever state the meter was in.
- R6: A measurement begins at the first synchronised slow rising edge after a restart. It ends at the 16th slow rising edge after that one, and `meas_count` then equals 16 times the number of main-clock cycles in one slow period.
- R7: Once `meas_ready` is 1, it and `meas_count` stay unchanged until the next `meas_start`.
- R8: `meas_count` saturates at 65535 instead of wrapping.
- R9: Releasing reset starts one measurement without any `meas_start` request.
- R10: A `meas_start` during a measurement abandons it. The next window starts from the following slow rising edge and yields a full, correct count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, for power-up and peripheral reset |
| slow_clk | input | 1 | Slow reference clock, sampled as data |
| fac_trim_lo | input | 8 | Factory trim code for the low range |
| fac_trim_mid | input | 8 | Factory trim code for the middle range |
| fac_trim_hi | input | 8 | Factory trim code for the high range |
| range_i | input | 2 | Active frequency range (0 low, 1 middle, 2 or 3 high) |
| usr_we | input | 1 | User trim write strobe |
| usr_range | input | 2 | Range targeted by the write (3 is ignored) |
| usr_trim | input | 8 | User trim code to store |
| usr_sel | input | 1 | Select bit to store (1 means use the user code) |
| trim_o | output | 8 | Trim code applied to the oscillator |
| meas_start | input | 1 | Restart frequency measurement |
| meas_ready | output | 1 | Measurement finished |
| meas_count | output | 16 | Main-clock cycles counted over the window |

## Verification
On every cycle the assertions check four things. A write reaches `trim_o` in the following cycle with the code that the select bit calls for. A restart clears the ready flag and the count. A finished result stays frozen until the next restart, and a saturated count never wraps. Only the bench scenarios can show the exact count for a given slow period, the start of the window at the edge after a restart, the measurement that starts by itself after reset, and the full recount after an aborted window, because each of these depends on the relative timing of the two clocks over many cycles.

// File: rtl/rc_trim_fmeter.sv
module rc_trim_fmeter #(
  parameter int TRIM_W  = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic [TRIM_W-1:0] fac_trim_lo,
  input  logic [TRIM_W-1:0] fac_trim_mid,
  input  logic [TRIM_W-1:0] fac_trim_hi,
  input  logic [1:0]        range_i,
  input  logic              usr_we,
  input  logic [1:0]        usr_range,
  input  logic [TRIM_W-1:0] usr_trim,
  input  logic              usr_sel,
  output logic [TRIM_W-1:0] trim_o,
  input  logic              meas_start,
  output logic              meas_ready,
  output logic [CNT_W-1:0]  meas_count
);
  localparam int EW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
  localparam logic [EW-1:0]    LAST_EDGE = EW'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic [TRIM_W-1:0] usr_lo, usr_mid, usr_hi;
  logic [2:0]        sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_lo  <= '0;
      usr_mid <= '0;
      usr_hi  <= '0;
      sel_q   <= '0;
    end else if (usr_we) begin
      case (usr_range)
        2'd0: begin usr_lo  <= usr_trim; sel_q[0] <= usr_sel; end
        2'd1: begin usr_mid <= usr_trim; sel_q[1] <= usr_sel; end
        2'd2: begin usr_hi  <= usr_trim; sel_q[2] <= usr_sel; end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (range_i)
      2'd0:    trim_o = sel_q[0] ? usr_lo  : fac_trim_lo;
      2'd1:    trim_o = sel_q[1] ? usr_mid : fac_trim_mid;
      default: trim_o = sel_q[2] ? usr_hi  : fac_trim_hi;
    endcase
  end

  logic [2:0] sync_q;
  wire        slow_rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= {sync_q[1:0], slow_clk};
  end

  logic             armed, running;
  logic [EW-1:0]    edges_q;
  logic [CNT_W-1:0] cnt_q;
  wire  [CNT_W-1:0] cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b1;
      running    <= 1'b0;
      meas_ready <= 1'b0;
      cnt_q      <= '0;
      edges_q    <= '0;
    end else if (meas_start) begin
      armed      <= 1'b1;
      running    <= 1'b0;
      meas_ready <= 1'b0;
      cnt_q      <= '0;
      edges_q    <= '0;
    end else if (armed) begin
      if (slow_rise) begin
        armed   <= 1'b0;
        running <= 1'b1;
        cnt_q   <= '0;
        edges_q <= '0;
      end
    end else if (running) begin
      cnt_q <= cnt_inc;
      if (slow_rise) begin
        if (edges_q == LAST_EDGE) begin
          running    <= 1'b0;
          meas_ready <= 1'b1;
        end else begin
          edges_q <= edges_q + 1'b1;
        end
      end
    end
  end

  assign meas_count = cnt_q;
endmodule

// File: rtl/rc_trim_fmeter_chk.sv
module rc_trim_fmeter_chk #(
  parameter int TRIM_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [TRIM_W-1:0] fac_trim_lo,
  input logic [TRIM_W-1:0] fac_trim_mid,
  input logic [TRIM_W-1:0] fac_trim_hi,
  input logic [1:0]        range_i,
  input logic              usr_we,
  input logic [1:0]        usr_range,
  input logic [TRIM_W-1:0] usr_trim,
  input logic              usr_sel,
  input logic [TRIM_W-1:0] trim_o,
  input logic              meas_start,
  input logic              meas_ready,
  input logic [CNT_W-1:0]  meas_count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  function automatic logic [TRIM_W-1:0] fac_of(input logic [1:0] r);
    case (r)
      2'd0:    fac_of = fac_trim_lo;
      2'd1:    fac_of = fac_trim_mid;
      default: fac_of = fac_trim_hi;
    endcase
  endfunction

  AST_USER_TRIM_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_we && usr_sel && usr_range != 2'd3 && usr_range == range_i)
    |=> (range_i != $past(range_i)) || (trim_o == $past(usr_trim))); // R4

  AST_FACTORY_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_we && !usr_sel && usr_range != 2'd3 && usr_range == range_i)
    |=> (range_i != $past(range_i)) || (trim_o == fac_of(range_i))); // R2

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    meas_start |=> (!meas_ready && meas_count == '0)); // R5

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_ready && !meas_start) |=> (meas_ready && $stable(meas_count))); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_count == CMAX && !meas_start) |=> (meas_count == CMAX)); // R8

  AST_READY_NOT_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_ready) |-> !$past(meas_start)); // R5
endmodule

bind rc_trim_fmeter rc_trim_fmeter_chk #(.TRIM_W(TRIM_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fac_trim_lo(fac_trim_lo), .fac_trim_mid(fac_trim_mid),
  .fac_trim_hi(fac_trim_hi), .range_i(range_i), .usr_we(usr_we), .usr_range(usr_range),
  .usr_trim(usr_trim), .usr_sel(usr_sel), .trim_o(trim_o), .meas_start(meas_start),
  .meas_ready(meas_ready), .meas_count(meas_count)
);

// File: tb/test_rc_trim_fmeter.sv
`timescale 1ns/1ps
module test_rc_trim_fmeter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic [7:0] fac_lo = 8'h41, fac_mid = 8'h82, fac_hi = 8'hC3;
  logic [1:0] range_i = 2'd0;
  logic       usr_we = 1'b0;
  logic [1:0] usr_range = 2'd0;
  logic [7:0] usr_trim = 8'h00;
  logic       usr_sel = 1'b0;
  logic [7:0] trim_o;
  logic       meas_start = 1'b0;
  logic       meas_ready;
  logic [15:0] meas_count;

  int n_vec = 0;
  int n_bad = 0;
  int slow_half = 5;
  bit done = 0;

  always #2.5 clk = ~clk;

  initial forever begin
    repeat (slow_half) @(negedge clk);
    slow_clk = ~slow_clk;
  end

  rc_trim_fmeter i_rc_trim_fmeter (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .fac_trim_lo(fac_lo), .fac_trim_mid(fac_mid), .fac_trim_hi(fac_hi),
    .range_i(range_i), .usr_we(usr_we), .usr_range(usr_range),
    .usr_trim(usr_trim), .usr_sel(usr_sel), .trim_o(trim_o),
    .meas_start(meas_start), .meas_ready(meas_ready), .meas_count(meas_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] r, input logic [7:0] v, input logic s);
    @(negedge clk);
    usr_we = 1'b1; usr_range = r; usr_trim = v; usr_sel = s;
    @(negedge clk);
    usr_we = 1'b0;
  endtask

  task automatic trim_at(input logic [1:0] r, input int exp, input string req);
    range_i = r;
    #0.1;
    chk(req, int'(trim_o), exp);
  endtask

  task automatic restart();
    @(negedge clk); meas_start = 1'b1;
    @(negedge clk); meas_start = 1'b0;
  endtask

  task automatic wait_ready(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      if (meas_ready) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic set_period(input int half);
    int old = slow_half;
    slow_half = half;
    repeat (4 * (old + half)) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R3 ready low after reset", int'(meas_ready), 0);
    chk("R3 count zero after reset", int'(meas_count), 0);
    trim_at(2'd0, 8'h41, "R3 low factory");
    trim_at(2'd1, 8'h82, "R3 mid factory");
    trim_at(2'd2, 8'hC3, "R3 high factory");
  endtask

  task automatic t_auto();
    bit ok;
    wait_ready(2000, ok);
    chk("R9 auto measurement finished", int'(ok), 1);
    chk("R9 R6 auto count P=10", int'(meas_count), 160);
  endtask

  task automatic t_trim();
    @(negedge clk);
    range_i = 2'd0;
    wr(2'd0, 8'h15, 1'b1);
    chk("R4 live low user trim", int'(trim_o), 8'h15);
    trim_at(2'd1, 8'h82, "R1 mid unaffected");
    wr(2'd1, 8'h2A, 1'b1);
    trim_at(2'd1, 8'h2A, "R2 mid user");
    trim_at(2'd2, 8'hC3, "R1 high still factory");
    trim_at(2'd3, 8'hC3, "R1 code 3 is high");
    wr(2'd2, 8'h5C, 1'b1);
    trim_at(2'd3, 8'h5C, "R1 code 3 high user");
    wr(2'd0, 8'h77, 1'b0);
    trim_at(2'd0, 8'h41, "R2 sel0 gives factory");
    wr(2'd0, 8'h77, 1'b1);
    trim_at(2'd0, 8'h77, "R2 sel1 gives user");
    wr(2'd3, 8'hFF, 1'b1);
    trim_at(2'd0, 8'h77, "R4 range3 write ignored lo");
    trim_at(2'd1, 8'h2A, "R4 range3 write ignored mid");
    trim_at(2'd2, 8'h5C, "R4 range3 write ignored hi");
    wr(2'd2, 8'h5D, 1'b1);
    chk("R4 live high change", int'(trim_o), 8'h5D);
    do_reset();
    trim_at(2'd0, 8'h41, "R3 peripheral reset low");
    trim_at(2'd1, 8'h82, "R3 peripheral reset mid");
    trim_at(2'd2, 8'hC3, "R3 peripheral reset high");
    range_i = 2'd0;
  endtask

  task automatic t_measure(input int half);
    bit ok;
    set_period(half);
    restart();
    chk("R5 ready cleared", int'(meas_ready), 0);
    chk("R5 count cleared", int'(meas_count), 0);
    wait_ready(40 * half + 100, ok);
    chk("R6 measurement finished", int'(ok), 1);
    chk("R6 count 16 periods", int'(meas_count), 32 * half);
  endtask

  task automatic t_restart_mid();
    bit ok;
    set_period(5);
    restart();
    repeat (60) @(negedge clk);
    chk("R10 running before abort", int'(meas_ready), 0);
    restart();
    chk("R10 R5 count cleared on abort", int'(meas_count), 0);
    wait_ready(400, ok);
    chk("R10 finished after abort", int'(ok), 1);
    chk("R10 full count after abort", int'(meas_count), 160);
  endtask

  task automatic t_hold();
    int held = meas_count;
    repeat (300) @(negedge clk);
    chk("R7 ready held", int'(meas_ready), 1);
    chk("R7 count held", int'(meas_count), held);
  endtask

  task automatic t_saturate();
    bit ok;
    set_period(2100);
    restart();
    wait_ready(80000, ok);
    chk("R8 long measurement finished", int'(ok), 1);
    chk("R8 count saturated", int'(meas_count), 65535);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_auto();
    t_trim();
    t_auto();
    t_measure(7);
    t_measure(3);
    t_restart_mid();
    t_hold();
    t_saturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule